// File: doc/BRIEF.md
# Strided Vector Load Engine over Interleaved Banks

This block turns one vector load command into a stream of element reads spread over a set of interleaved, unpipelined memory banks. The command gives a base word address, a stride (in words, taken modulo the address width) and a vector length. Element `i` lives at `base + i*stride`. The low address bits choose the bank, and the remaining bits give the row inside that bank. The engine issues at most one element request per cycle, always in element order. When the bank of the next element is still busy, it holds that element back.

Each bank is unpipelined and takes a fixed number of cycles per access. A per-bank down-counter in the engine marks the bank as busy until the access completes. Bank data comes back on a fixed-latency lane per bank. Each element is then written into a vector register write port together with its element index. Because the schedule is strictly in order, the write indices rise by one per write. A one-cycle done pulse closes each command.

Top module: `vec_stride_load`

## Requirements
- R1: After reset `busy`, `done`, `wr_en` and every `bank_req` bit are 0.
- R2: Once a bank has been sent a request, it receives no further request for LAT cycles (default 6). The earliest next request comes exactly LAT cycles after the previous one.
- R3: Element `i` is requested at address `base + i*stride` (mod 2^AW). `bank_req` is one-hot on bit `addr[2:0]`, `bank_row` carries `addr[AW-1:3]`, and at most one request is made per cycle, in ascending element order.
- R4: If the next element's bank is busy, no request is made that cycle. The element is issued in the first cycle its bank is free. The first element is issued in the cycle after `start` is accepted.
- R5: Element `i` appears on the write port exactly LAT cycles after its request. `wr_idx = i` and `wr_data` equals the bank lane's data for that element's address, and writes occur in ascending index order.
- R6: With a stride that is odd (relatively prime to 8) and LAT ≤ 8, nothing stalls. The last element is written LAT+VL cycles after the `start` cycle.
- R7: With a stride that is a multiple of 8, every element hits one bank, and a new element issues only every LAT cycles.
- R8: `done` is high for exactly one cycle, the cycle after the last write. `busy` is low in that cycle.
- R9: A length of zero issues no requests and makes no writes. `done` pulses in the cycle after `start`.
- R10: `start` while `busy` is high is ignored; the running command is unaffected.
- R11: A length above VLMAX (64) is treated as VLMAX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (accepted only while idle) |
| base_addr | input | AW | Word address of element 0 |
| stride | input | AW | Word distance between elements |
| vlen | input | $clog2(VLMAX+1) | Number of elements |
| bank_rdata | input | NB*W | Per-bank read data lanes, lane b at bits [b*W +: W] |
| bank_req | output | NB | One-hot request strobe to the chosen bank |
| bank_row | output | AW-$clog2(NB) | Row address inside the chosen bank |
| wr_en | output | 1 | Vector register write strobe |
| wr_idx | output | $clog2(VLMAX) | Element index being written |
| wr_data | output | W | Element data being written |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong bank counter shows up at the ports in one of two ways. It can send a request to a bank inside its busy window, which is visible at once on `bank_req`. Or it can delay an issue, which shifts every later write and so moves `done` by the same number of cycles. A wrong address step or bank select is visible in the request cycle as the wrong `bank_req` bit or `bank_row`. It is visible again LAT cycles later as wrong `wr_data`. A lost or extra tracked element breaks the rising `wr_idx` order at the next write and leaves `done` early, late or missing.

// File: rtl/vsl_pkg.sv
package vsl_pkg;

    // Saturate a requested element count to the register length.
    function automatic int unsigned clip_len(input int unsigned req, input int unsigned cap);
        return (req > cap) ? cap : req;
    endfunction

endpackage

// File: rtl/vsl_bank_timer.sv
// Busy timer for one unpipelined bank: loaded on issue, counts to zero.
module vsl_bank_timer #(
    parameter int LAT = 6,
    localparam int CW = $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic idle
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = CW'(LAT - 1);
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - CW'(1);
        end
        idle = (tmr_q.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/vsl_issue_ctrl.sv
// Address generation, bank selection and stall decision for one command.
module vsl_issue_ctrl #(
    parameter int NB    = 8,
    parameter int AW    = 32,
    parameter int VLMAX = 64,
    localparam int BW = $clog2(NB),
    localparam int IW = $clog2(VLMAX),
    localparam int LW = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    base_addr,
    input  logic [AW-1:0]    stride,
    input  logic [LW-1:0]    vlen,
    input  logic [NB-1:0]    bank_idle,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    output logic             req_fire,
    output logic [NB-1:0]    req_onehot,
    output logic [BW-1:0]    req_bank,
    output logic [AW-BW-1:0] req_row,
    output logic [IW-1:0]    req_idx,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [AW-1:0] addr;
        logic [AW-1:0] step;
        logic [LW-1:0] nidx;
        logic [LW-1:0] len;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LW-1:0] len_eff;
    logic          more;
    logic          last_wr;

    always_comb begin
        len_eff    = LW'(vsl_pkg::clip_len(32'(vlen), 32'(VLMAX)));
        more       = ctl_q.busy && (ctl_q.nidx != ctl_q.len);
        req_bank   = ctl_q.addr[BW-1:0];
        req_row    = ctl_q.addr[AW-1:BW];
        req_idx    = ctl_q.nidx[IW-1:0];
        req_fire   = more && bank_idle[req_bank];
        req_onehot = '0;
        if (req_fire) begin
            req_onehot[req_bank] = 1'b1;
        end
        last_wr = ctl_q.busy && wr_en && (LW'(wr_idx) == (ctl_q.len - LW'(1)));

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (!ctl_q.busy) begin
            if (start) begin
                if (len_eff == '0) begin
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.busy = 1'b1;
                    ctl_d.addr = base_addr;
                    ctl_d.step = stride;
                    ctl_d.nidx = '0;
                    ctl_d.len  = len_eff;
                end
            end
        end else begin
            if (req_fire) begin
                ctl_d.addr = ctl_q.addr + ctl_q.step;
                ctl_d.nidx = ctl_q.nidx + LW'(1);
            end
            if (last_wr) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end
        busy = ctl_q.busy;
        done = ctl_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/vsl_return_pipe.sv
// Tracks in-flight elements for LAT cycles and steers the bank lane to the write port.
module vsl_return_pipe #(
    parameter int NB    = 8,
    parameter int LAT   = 6,
    parameter int W     = 32,
    parameter int VLMAX = 64,
    localparam int BW = $clog2(NB),
    localparam int IW = $clog2(VLMAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [BW-1:0]   push_bank,
    input  logic [IW-1:0]   push_idx,
    input  logic [NB*W-1:0] bank_rdata,
    output logic            wr_en,
    output logic [IW-1:0]   wr_idx,
    output logic [W-1:0]    wr_data
);

    typedef struct packed {
        logic          vld;
        logic [BW-1:0] bank;
        logic [IW-1:0] idx;
    } ent_t;

    typedef struct packed {
        ent_t [LAT-1:0] stg;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    ent_t  tail;

    always_comb begin
        pipe_d            = pipe_q;
        pipe_d.stg[0].vld  = push;
        pipe_d.stg[0].bank = push_bank;
        pipe_d.stg[0].idx  = push_idx;
        for (int k = 1; k < LAT; k++) begin
            pipe_d.stg[k] = pipe_q.stg[k-1];
        end
        tail    = pipe_q.stg[LAT-1];
        wr_en   = tail.vld;
        wr_idx  = tail.idx;
        wr_data = bank_rdata[tail.bank*W +: W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

endmodule

// File: rtl/vec_stride_load.sv
// Strided vector load engine in front of NB interleaved unpipelined banks.
module vec_stride_load #(
    parameter int NB    = 8,
    parameter int LAT   = 6,
    parameter int AW    = 32,
    parameter int W     = 32,
    parameter int VLMAX = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [AW-1:0]                  base_addr,
    input  logic [AW-1:0]                  stride,
    input  logic [$clog2(VLMAX+1)-1:0]     vlen,
    input  logic [NB*W-1:0]                bank_rdata,
    output logic [NB-1:0]                  bank_req,
    output logic [AW-$clog2(NB)-1:0]       bank_row,
    output logic                           wr_en,
    output logic [$clog2(VLMAX)-1:0]       wr_idx,
    output logic [W-1:0]                   wr_data,
    output logic                           busy,
    output logic                           done
);

    localparam int BW = $clog2(NB);
    localparam int IW = $clog2(VLMAX);

    logic [NB-1:0] bank_idle;
    logic          req_fire;
    logic [BW-1:0] req_bank;
    logic [IW-1:0] req_idx;

    vsl_issue_ctrl #(
        .NB(NB), .AW(AW), .VLMAX(VLMAX)
    ) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .base_addr  (base_addr),
        .stride     (stride),
        .vlen       (vlen),
        .bank_idle  (bank_idle),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .req_fire   (req_fire),
        .req_onehot (bank_req),
        .req_bank   (req_bank),
        .req_row    (bank_row),
        .req_idx    (req_idx),
        .busy       (busy),
        .done       (done)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        vsl_bank_timer #(.LAT(LAT)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (bank_req[b]),
            .idle  (bank_idle[b])
        );
    end

    vsl_return_pipe #(
        .NB(NB), .LAT(LAT), .W(W), .VLMAX(VLMAX)
    ) u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (req_fire),
        .push_bank  (req_bank),
        .push_idx   (req_idx),
        .bank_rdata (bank_rdata),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data)
    );

endmodule

// File: rtl/vsl_checker.sv
// Port-level properties of the load engine, attached by bind.
module vsl_checker #(
    parameter int NB    = 8,
    parameter int LAT   = 6,
    parameter int VLMAX = 64,
    localparam int IW = $clog2(VLMAX),
    localparam int CW = $clog2(LAT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [NB-1:0] bank_req,
    input logic          wr_en,
    input logic [IW-1:0] wr_idx
);

    logic [CW-1:0] since_q [NB];
    logic [IW-1:0] next_idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) since_q[b] <= CW'(LAT);
            next_idx_q <= '0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (bank_req[b]) since_q[b] <= CW'(1);
                else if (since_q[b] != CW'(LAT)) since_q[b] <= since_q[b] + CW'(1);
            end
            if (done) next_idx_q <= '0;
            else if (wr_en) next_idx_q <= next_idx_q + IW'(1);
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_gap
        // R2
        bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bank_req[b] |-> (since_q[b] >= CW'(LAT)));
    end

    // R3
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_req));

    // R9
    req_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_req != '0) |-> busy);

    // R5
    idx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx == next_idx_q));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !wr_en));

endmodule

bind vec_stride_load vsl_checker #(.NB(NB), .LAT(LAT), .VLMAX(VLMAX)) u_vsl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .bank_req (bank_req),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx)
);

// File: tb/vec_stride_load_bench.sv
module vec_stride_load_bench;

    localparam int NB    = 8;
    localparam int LAT   = 6;
    localparam int AW    = 32;
    localparam int W     = 32;
    localparam int VLMAX = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [AW-1:0]     base_addr = '0;
    logic [AW-1:0]     stride_in = '0;
    logic [6:0]        vlen = '0;
    logic [NB*W-1:0]   bank_rdata = '0;
    logic [NB-1:0]     bank_req;
    logic [AW-4:0]     bank_row;
    logic              wr_en;
    logic [5:0]        wr_idx;
    logic [W-1:0]      wr_data;
    logic              busy;
    logic              done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vec_stride_load #(.NB(NB), .LAT(LAT), .AW(AW), .W(W), .VLMAX(VLMAX)) u_vec_stride_load (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .stride(stride_in),
        .vlen(vlen), .bank_rdata(bank_rdata), .bank_req(bank_req), .bank_row(bank_row),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .busy(busy), .done(done)
    );

    function automatic logic [31:0] fdat(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] eaddr(input logic [31:0] b, input logic [31:0] s, input int i);
        return b + s * 32'(i);
    endfunction

    // Bank model: data for a request appears on the lane LAT cycles later.
    int          pend_cnt [NB];
    logic [31:0] pend_addr [NB];
    initial for (int b = 0; b < NB; b++) pend_cnt[b] = 0;

    always @(negedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (pend_cnt[b] != 0) begin
                pend_cnt[b] = pend_cnt[b] - 1;
                if (pend_cnt[b] == 0) bank_rdata[b*W +: W] = fdat(pend_addr[b]);
            end
            if (bank_req[b]) begin
                pend_cnt[b]  = LAT;
                pend_addr[b] = {bank_row, 3'(b)};
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Runs one command; span = last write cycle minus start cycle, cnt = writes seen.
    task automatic run_vec(input logic [31:0] base, input logic [31:0] stride, input int vl_req,
                           input bit poke, output int span, output int cnt);
        int vl;
        int rel [VLMAX];
        int freeb [NB];
        int t;
        int s;
        int k;
        int ni;
        int lastw;
        bit fin;
        logic [31:0] a;
        vl = (vl_req > VLMAX) ? VLMAX : vl_req;
        for (int b = 0; b < NB; b++) freeb[b] = 0;
        t = 1;
        for (int i = 0; i < vl; i++) begin
            a = eaddr(base, stride, i);
            if (freeb[a[2:0]] > t) t = freeb[a[2:0]];
            rel[i] = t;
            freeb[a[2:0]] = t + LAT;
            t++;
        end
        @(negedge clk);
        start = 1'b1; base_addr = base; stride_in = stride; vlen = 7'(vl_req);
        s = cyc; k = 0; ni = 0; fin = 0; lastw = s;
        for (int n = 1; n <= VLMAX * LAT + 20 && !fin; n++) begin
            @(negedge clk);
            if (poke && n == 2) begin
                start = 1'b1; base_addr = ~base; stride_in = stride + 1; vlen = 7'd3;
            end else begin
                start = 1'b0;
            end
            #1;
            if (ni < vl && cyc == s + rel[ni]) begin
                a = eaddr(base, stride, ni);
                // R3: bank = addr[2:0], row = addr[31:3]
                chk(bank_req == (8'b1 << a[2:0]) && bank_row == a[31:3], "R3",
                    {24'(bank_req), 32'(bank_row)}, {24'(8'b1 << a[2:0]), 32'(a[31:3])});
                ni++;
            end else begin
                // R4: stalled or finished, no request
                chk(bank_req == '0, "R4", 64'(bank_req), 64'd0);
            end
            if (wr_en) begin
                a = eaddr(base, stride, k);
                // R5: index, data and cycle of each write
                chk(k < vl && wr_idx == 6'(k) && wr_data == fdat(a) && cyc == s + rel[k] + LAT, "R5",
                    {16'(cyc - s), 8'(wr_idx), wr_data}, {16'(rel[k] + LAT), 8'(k), fdat(a)});
                lastw = cyc;
                k++;
            end
            if (done) begin
                fin = 1;
                // R8: done one cycle after last write, idle
                chk(cyc == ((vl == 0) ? s + 1 : lastw + 1) && !busy, "R8",
                    64'(cyc - s), 64'((vl == 0) ? 1 : lastw - s + 1));
            end
        end
        if (!fin) chk(1'b0, "R8", 64'd0, 64'd1);
        @(negedge clk);
        // R8: done is a single-cycle pulse
        chk(!done, "R8", 64'(done), 64'd0);
        span = lastw - s;
        cnt = k;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int span;
        int cnt;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(!busy && !done && !wr_en && bank_req == '0, "R1",
            {60'd0, busy, done, wr_en, |bank_req}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!busy && !done && !wr_en && bank_req == '0, "R1",
            {60'd0, busy, done, wr_en, |bank_req}, 64'd0);

        // R6: unit stride, full length, no stalls
        run_vec(32'h100, 32'd1, 64, 0, span, cnt);
        chk(span == LAT + 64 && cnt == 64, "R6", {32'(span), 32'(cnt)}, {32'(LAT + 64), 32'd64});
        // R6: odd stride, no stalls
        run_vec(32'h2345, 32'd3, 40, 0, span, cnt);
        chk(span == LAT + 40, "R6", 64'(span), 64'(LAT + 40));
        // R7 and R2: stride 8 hits one bank, one element per LAT cycles
        run_vec(32'h40, 32'd8, 5, 0, span, cnt);
        chk(span == 5 * LAT + 1, "R7", 64'(span), 64'(5 * LAT + 1));
        // R4: stride 2 uses four banks, groups of four every LAT cycles
        run_vec(32'h10, 32'd2, 16, 0, span, cnt);
        chk(span == 28, "R4", 64'(span), 64'd28);
        // R4: stride 4 uses two banks
        run_vec(32'h7, 32'd4, 8, 0, span, cnt);
        chk(span == 26, "R4", 64'(span), 64'd26);
        // R9: zero length
        run_vec(32'h55, 32'd1, 0, 0, span, cnt);
        chk(cnt == 0, "R9", 64'(cnt), 64'd0);
        // R10: second start while busy ignored
        run_vec(32'h300, 32'd1, 10, 1, span, cnt);
        chk(cnt == 10 && span == LAT + 10, "R10", {32'(cnt), 32'(span)}, {32'd10, 32'(LAT + 10)});
        // R11: length above the maximum is clamped
        run_vec(32'h900, 32'd5, 100, 0, span, cnt);
        chk(cnt == VLMAX, "R11", 64'(cnt), 64'(VLMAX));
        // R3: address wraps around the top of the space
        run_vec(32'hFFFF_FFF0, 32'd5, 20, 0, span, cnt);
        chk(cnt == 20, "R3", 64'(cnt), 64'd20);

        for (int r = 0; r < 24; r++) begin
            logic [31:0] rb;
            logic [31:0] rs;
            int rl;
            rb = $urandom;
            rs = ($urandom % 4 == 0) ? $urandom : 32'($urandom % 17);
            rl = int'($urandom % 72);
            run_vec(rb, rs, rl, r % 5 == 1 && rl != 0, span, cnt);
            chk(cnt == ((rl > VLMAX) ? VLMAX : rl), "R5", 64'(cnt), 64'((rl > VLMAX) ? VLMAX : rl));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule